// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Unit

This unit keeps a 12-bit program counter and pulls instructions out of a byte-wide synchronous program memory. The memory has a one-cycle read latency. An instruction is either one byte or two bytes long, and its length is decided from the first byte alone. For a long instruction the unit reads one more byte. It then hands both opcode bytes, the length flag and the instruction's start address to an execute stage, together with a one-clock valid strobe.

Each fetch step happens only on a clock where the cycle-enable input is high, so a slow tick can pace the unit. A jump load sets a new program counter at any time and discards any instruction that is only half fetched. The address bus moves forward one byte on every enabled clock. A one-byte instruction therefore retires in one enabled cycle and a two-byte instruction in two.

Top module: `instr_fetch_unit`

## Requirements
- R1: While reset is high, mem_addr is 0x000. After reset, pc is 0x000 and instr_valid is low.
- R2: An instruction is two bytes long when the upper nibble of its first byte is 0x1, 0x4, 0x5 or 0x7, or is 0x2 with bit 0 clear. Every other first byte starts a one-byte instruction. instr_two reports the result (1 means two bytes).
- R3: A one-byte instruction completes on a single enabled clock. It shows its opcode on instr_byte0, and instr_byte1 is 0x00.
- R4: A two-byte instruction completes on its second enabled clock. instr_byte0 holds the byte at the start address and instr_byte1 holds the next byte. No strobe is given after the first of the two clocks.
- R5: On completion, instr_pc gives the start address and pc advances by the length (1 or 2). Back-to-back instructions are fetched with no idle cycles.
- R6: Address arithmetic wraps modulo 4096. A two-byte instruction at 0xFFF takes its second byte from 0x000 and leaves pc at 0x001.
- R7: A clock with en low changes nothing. pc and mem_addr hold, no strobe is given, and a half-fetched instruction resumes when en returns.
- R8: jump_valid loads jump_target into pc whatever en is. It aborts a partial fetch and suppresses the strobe on that clock. The next instruction comes from the target.
- R9: instr_valid is high for exactly one clock per completed instruction, and only after a clock with en high and no jump.
- R10: mem_addr is the address sampled by the memory on each rising edge. The read data is expected on mem_rdata during the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Cycle enable for fetch steps |
| jump_valid | input | 1 | Load a new program counter |
| jump_target | input | 12 | New program counter value |
| mem_addr | output | 12 | Program memory read address |
| mem_rdata | input | 8 | Program memory read data, one cycle after address |
| instr_valid | output | 1 | One-clock strobe for a completed instruction |
| instr_byte0 | output | 8 | First opcode byte |
| instr_byte1 | output | 8 | Second opcode byte, zero for one-byte instructions |
| instr_two | output | 1 | Instruction is two bytes long |
| instr_pc | output | 12 | Start address of the delivered instruction |
| pc | output | 12 | Start address of the next instruction |

## Verification
Suppose the read pointer and the phase register fall out of step. The next strobe then carries a byte from the wrong address, and its instr_pc or the following pc is off by one. This shows at the very next completion, one or two enabled clocks later. A wrong length decision splits or merges opcode bytes, and instr_two together with the count of enabled clocks before the strobe shows it at once. A lost hold during a stall moves mem_addr on the first disabled clock. A failed abort shows as a strobe just after the jump.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    localparam int PC_W   = 12;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;

    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [NIB_W-1:0]  nib_t;

    typedef enum logic [0:0] {
        PH_HEAD = 1'b0,
        PH_TAIL = 1'b1
    } phase_e;

    typedef struct packed {
        byte_t b0;
        byte_t b1;
        logic  two;
        pc_t   at;
    } instr_t;

    // Upper nibble values that always mean a long instruction
    localparam nib_t LONG_A = nib_t'(4'h1);
    localparam nib_t LONG_B = nib_t'(4'h4);
    localparam nib_t LONG_C = nib_t'(4'h5);
    localparam nib_t LONG_D = nib_t'(4'h7);
    // Nibble that is long only when bit 0 is clear
    localparam nib_t LONG_E = nib_t'(4'h2);

    function automatic logic is_two_byte(byte_t op);
        nib_t hi;
        hi = op[BYTE_W-1:NIB_W];
        if (hi == LONG_A || hi == LONG_B || hi == LONG_C || hi == LONG_D)
            return 1'b1;
        if (hi == LONG_E)
            return ~op[0];
        return 1'b0;
    endfunction

endpackage

// File: rtl/ifu_len_decode.sv
module ifu_len_decode
    import ifu_pkg::*;
(
    input  byte_t op,
    output logic  two
);
    always_comb two = is_two_byte(op);
endmodule

// File: rtl/ifu_pointer.sv
module ifu_pointer
    import ifu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   jump_valid,
    input  pc_t    jump_target,
    input  logic   complete,
    input  phase_e phase,
    output pc_t    mem_addr,
    output pc_t    ptr,
    output pc_t    pc
);
    pc_t ptr_q, pc_q;

    // Address presented to the memory this cycle; data arrives next cycle
    always_comb begin
        if (rst)             mem_addr = '0;
        else if (jump_valid) mem_addr = jump_target;
        else if (en)         mem_addr = ptr_q + pc_t'(1);
        else                 mem_addr = ptr_q;
    end

    always_ff @(posedge clk) begin
        ptr_q <= mem_addr;
        if (rst)             pc_q <= '0;
        else if (jump_valid) pc_q <= jump_target;
        else if (complete)   pc_q <= ptr_q + pc_t'(1);
    end

    assign ptr = ptr_q;
    assign pc  = pc_q;

    // R5: read pointer sits on the next instruction start in head phase
    assert_head_aligned_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HEAD) |-> (ptr_q == pc_q));
    // R5, R6: in tail phase the pointer is one byte past the start, modulo 4096
    assert_tail_offset_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TAIL) |-> (ptr_q == pc_q + pc_t'(1)));
    // R8: a jump lands in the program counter
    assert_jump_load_R8: assert property (@(posedge clk) disable iff (rst)
        jump_valid |=> (pc_q == $past(jump_target)));
    // R7: disabled cycle keeps all address state
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!en && !jump_valid) |=> ($stable(pc_q) && $stable(ptr_q)));

endmodule

// File: rtl/ifu_sequencer.sv
module ifu_sequencer
    import ifu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   jump_valid,
    input  byte_t  rdata,
    input  logic   head_two,
    input  pc_t    pc,
    output phase_e phase,
    output logic   complete,
    output logic   out_valid,
    output instr_t out_instr
);
    phase_e phase_q;
    byte_t  held_q;
    logic   valid_q;
    instr_t instr_q;
    logic   step;

    assign step     = en && !jump_valid;
    assign complete = step && ((phase_q == PH_TAIL) || !head_two);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HEAD;
            held_q  <= '0;
            valid_q <= 1'b0;
            instr_q <= '0;
        end else if (jump_valid) begin
            phase_q <= PH_HEAD;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (en) begin
                unique case (phase_q)
                    PH_HEAD: begin
                        if (head_two) begin
                            held_q  <= rdata;
                            phase_q <= PH_TAIL;
                        end else begin
                            valid_q <= 1'b1;
                            instr_q <= '{b0: rdata, b1: '0, two: 1'b0, at: pc};
                        end
                    end
                    PH_TAIL: begin
                        valid_q <= 1'b1;
                        instr_q <= '{b0: held_q, b1: rdata, two: 1'b1, at: pc};
                        phase_q <= PH_HEAD;
                    end
                    default: phase_q <= PH_HEAD;
                endcase
            end
        end
    end

    assign phase     = phase_q;
    assign out_valid = valid_q;
    assign out_instr = instr_q;

    // R4: a tail step always returns to head phase
    assert_tail_returns_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TAIL && step) |=> (phase_q == PH_HEAD));
    // R9: strobe only follows an enabled, non-jump clock
    assert_strobe_cause_R9: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(step));
    // R3: short instructions carry a zero second byte
    assert_short_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !instr_q.two) |-> (instr_q.b1 == '0));
    // R8: nothing is delivered on the clock after a jump
    assert_jump_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        jump_valid |=> !valid_q);

endmodule

// File: rtl/instr_fetch_unit.sv
module instr_fetch_unit
    import ifu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        jump_valid,
    input  logic [11:0] jump_target,
    output logic [11:0] mem_addr,
    input  logic [7:0]  mem_rdata,
    output logic        instr_valid,
    output logic [7:0]  instr_byte0,
    output logic [7:0]  instr_byte1,
    output logic        instr_two,
    output logic [11:0] instr_pc,
    output logic [11:0] pc
);
    phase_e phase;
    logic   complete;
    logic   head_two;
    pc_t    ptr;
    pc_t    pc_w;
    instr_t instr;

    ifu_len_decode u_len (
        .op  (mem_rdata),
        .two (head_two)
    );

    ifu_pointer u_ptr (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .jump_valid  (jump_valid),
        .jump_target (jump_target),
        .complete    (complete),
        .phase       (phase),
        .mem_addr    (mem_addr),
        .ptr         (ptr),
        .pc          (pc_w)
    );

    ifu_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .jump_valid (jump_valid),
        .rdata      (mem_rdata),
        .head_two   (head_two),
        .pc         (pc_w),
        .phase      (phase),
        .complete   (complete),
        .out_valid  (instr_valid),
        .out_instr  (instr)
    );

    assign pc          = pc_w;
    assign instr_byte0 = instr.b0;
    assign instr_byte1 = instr.b1;
    assign instr_two   = instr.two;
    assign instr_pc    = instr.at;

    // R1: the reset read targets address zero
    always_comb begin
        if (rst) assert_reset_addr_R1: assert (mem_addr == '0);
    end
    // R10, R7: a disabled clock re-reads the same address
    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!en && !jump_valid) |-> (mem_addr == ptr));

endmodule

// File: tb/instr_fetch_unit_bench.sv
module instr_fetch_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;
    localparam int WATCHDOG_CYCLES = 20000;

    // {first byte, expected two-byte flag}
    localparam logic [8:0] VEC [NVEC] = '{
        {8'h00, 1'b0}, {8'h10, 1'b1}, {8'h1F, 1'b1}, {8'h20, 1'b1},
        {8'h21, 1'b0}, {8'h2E, 1'b1}, {8'h2F, 1'b0}, {8'h3A, 1'b0},
        {8'h40, 1'b1}, {8'h5C, 1'b1}, {8'h68, 1'b0}, {8'h7F, 1'b1},
        {8'h83, 1'b0}, {8'h96, 1'b0}, {8'hA5, 1'b0}, {8'hFE, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        jump_valid = 1'b0;
    logic [11:0] jump_target = '0;
    logic [11:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        instr_valid;
    logic [7:0]  instr_byte0;
    logic [7:0]  instr_byte1;
    logic        instr_two;
    logic [11:0] instr_pc;
    logic [11:0] pc;

    logic [7:0] mem [256];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) mem_rdata <= mem[mem_addr[7:0]];

    instr_fetch_unit u_instr_fetch_unit (
        .clk(clk), .rst(rst), .en(en), .jump_valid(jump_valid),
        .jump_target(jump_target), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .instr_valid(instr_valid), .instr_byte0(instr_byte0),
        .instr_byte1(instr_byte1), .instr_two(instr_two),
        .instr_pc(instr_pc), .pc(pc)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_jump(logic [11:0] t);
        jump_valid  = 1'b1;
        jump_target = t;
        tick();
        jump_valid  = 1'b0;
    endtask

    task automatic run_to_valid(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (!instr_valid && n < 4);
    endtask

    task automatic expect_instr(string tag, logic [7:0] b0, logic [7:0] b1,
                                logic two, logic [11:0] at, logic [11:0] nxt);
        check({tag, " valid"}, instr_valid, 1);
        check({tag, " byte0"}, instr_byte0, b0);
        check({tag, " byte1"}, instr_byte1, b1);
        check({tag, " two"},   instr_two, two);
        check({tag, " instr_pc"}, instr_pc, at);
        check({tag, " pc"}, pc, nxt);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hF0;
        mem[8'h00] = 8'h00; mem[8'h01] = 8'h12;
        mem[8'h02] = 8'h34; mem[8'h03] = 8'hD5;

        // R1 / R10: reset state
        @(negedge clk);
        tick(); tick();
        check("R1 reset mem_addr", mem_addr, 12'h000);
        check("R1 reset pc", pc, 12'h000);
        check("R1 reset valid", instr_valid, 0);

        // R5 / R9 / R10: back-to-back stream from address 0
        rst = 1'b0;
        en  = 1'b1;
        tick();
        expect_instr("R3 R5 seq1", 8'h00, 8'h00, 1'b0, 12'h000, 12'h001);
        tick();
        check("R4 R9 seq2 no strobe mid-fetch", instr_valid, 0);
        tick();
        expect_instr("R4 R5 seq2", 8'h12, 8'h34, 1'b1, 12'h001, 12'h003);
        tick();
        expect_instr("R5 R9 seq3", 8'hD5, 8'h00, 1'b0, 12'h003, 12'h004);

        // R2 / R3 / R4: table of first bytes
        for (int i = 0; i < NVEC; i++) begin
            logic [11:0] a;
            int n;
            a = 12'h010 + 12'(i * 4);
            mem[a[7:0]]      = VEC[i][8:1];
            mem[a[7:0] + 1]  = 8'hA0 | 8'(i);
            do_jump(a);
            run_to_valid(n);
            check($sformatf("R2 vec%0d cycles", i), n, VEC[i][0] ? 2 : 1);
            expect_instr($sformatf("R2 vec%0d", i), VEC[i][8:1],
                         VEC[i][0] ? (8'hA0 | 8'(i)) : 8'h00, VEC[i][0],
                         a, a + (VEC[i][0] ? 12'd2 : 12'd1));
        end

        // R7: stall mid two-byte fetch
        mem[8'h80] = 8'h45; mem[8'h81] = 8'h67;
        do_jump(12'h080);
        tick();
        check("R7 first half no strobe", instr_valid, 0);
        en = 1'b0;
        for (int k = 0; k < 5; k++) begin
            tick();
            check("R7 stall valid", instr_valid, 0);
            check("R7 stall mem_addr", mem_addr, 12'h081);
            check("R7 stall pc", pc, 12'h080);
        end
        en = 1'b1;
        tick();
        expect_instr("R7 resume", 8'h45, 8'h67, 1'b1, 12'h080, 12'h082);

        // R8: jump aborts a partial fetch
        mem[8'h90] = 8'h7A; mem[8'h91] = 8'h11; mem[8'hA0] = 8'hC3;
        do_jump(12'h090);
        tick();
        do_jump(12'h0A0);
        check("R8 abort no strobe", instr_valid, 0);
        check("R8 abort pc", pc, 12'h0A0);
        tick();
        expect_instr("R8 target", 8'hC3, 8'h00, 1'b0, 12'h0A0, 12'h0A1);

        // R8: jump acts with en low
        en = 1'b0;
        do_jump(12'h0B0);
        check("R8 jump en low pc", pc, 12'h0B0);
        check("R8 jump en low mem_addr", mem_addr, 12'h0B0);
        check("R8 jump en low valid", instr_valid, 0);

        // R6: wraparound at top of memory
        mem[8'hFE] = 8'hE0; mem[8'hFF] = 8'h1B; mem[8'h00] = 8'h9C;
        en = 1'b1;
        do_jump(12'hFFE);
        tick();
        expect_instr("R6 short at FFE", 8'hE0, 8'h00, 1'b0, 12'hFFE, 12'hFFF);
        tick();
        check("R6 mid wrap no strobe", instr_valid, 0);
        tick();
        expect_instr("R6 long at FFF", 8'h1B, 8'h9C, 1'b1, 12'hFFF, 12'h001);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule